// File: doc/BRIEF.md
# Pipelined Signed Multiplier Built from Nine Tiles

This block multiplies two signed two's complement operands, 52 bits wide by default, and returns their full double-width signed product. The intended use is inside a fixed-point control datapath. There, several coefficient-by-sample products must be formed in each control step. The target fabric offers only small signed multiply tiles that are 18 bits on each side.

The block takes the sign off each operand and works on the remaining magnitudes. Each magnitude is cut into three equal unsigned limbs, 17 bits each at the default width. That gives nine unsigned limb-by-limb products, and each of them fits one 18x18 signed tile. The nine products are shifted to their weights and added. The XOR of the two operand signs is then applied to the sum.

The one operand value whose magnitude cannot be represented is the most negative value. It is treated as the most negative value plus one, and a flag reports this. The block accepts a new operand pair on every clock cycle. The result appears three cycles later.

Top module: `wide_tile_mult`

## Requirements
- R1: For operands that are not the most negative value and whose product is not negative, `prod_out` equals the exact product of the two operands, taken as a 2*OPW-bit two's complement value.
- R2: `valid_out` repeats `valid_in` exactly three rising clock edges later, and this includes idle gaps in the input stream.
- R3: The sign of a nonzero result is the XOR of the operand sign bits. Negative products are exact. A zero operand gives an all-zero `prod_out`, never a negative zero.
- R4: An operand equal to the most negative value (sign bit 1, all other bits 0) is treated as the most negative value plus one. `clamp_out` is 1 on the result of that pair.
- R5: `clamp_out` is 0 on the result of any pair in which neither operand is the most negative value.
- R6: While `rst_n` is low, `valid_out`, `clamp_out` and `prod_out` are all 0.
- R7: A new operand pair is accepted on every cycle with no stall. Back-to-back pairs each produce their own result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operand pair on `a_in`/`b_in` is valid this cycle |
| a_in | input | OPW | First operand, two's complement |
| b_in | input | OPW | Second operand, two's complement |
| valid_out | output | 1 | `prod_out` and `clamp_out` carry a result |
| prod_out | output | 2*OPW | Signed product, two's complement |
| clamp_out | output | 1 | A most-negative operand was clamped for this result |

## Verification
Two functions can fall in the same cycle. The clamp of a most-negative operand and the final negation of the sum can both apply to one result. In addition, a clamped pair can sit directly behind or ahead of an ordinary pair in the pipeline.

These cases are provoked in two ways. The first sweeps every operand pair of a 7-bit instance with no gaps. The second runs corner pairs of the 52-bit instance (zero, plus and minus one, the largest positive value, the most negative value and its negation, values at limb boundaries) in all combinations, followed by random pairs with periodic idle gaps.

Each result is judged against an arithmetic product of the clamped operands, taken three cycles after the input. The flag and the valid bit are judged in the same cycle as the product.

// File: rtl/wide_tile_mult.sv
module wide_tile_mult #(
  parameter int OPW = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [OPW-1:0]   a_in,
  input  logic [OPW-1:0]   b_in,
  output logic             valid_out,
  output logic [2*OPW-1:0] prod_out,
  output logic             clamp_out
);
  localparam int MAGW = OPW - 1;
  localparam int LW   = (MAGW + 2) / 3;
  localparam int PADW = 3 * LW;
  localparam int PPW  = 2 * LW;
  localparam int RW   = 2 * OPW;
  localparam int NT   = 9;
  localparam logic [OPW-1:0] MINV = {1'b1, {MAGW{1'b0}}};

  function automatic logic [PADW-1:0] mag_of(input logic [OPW-1:0] x);
    logic [OPW-1:0] n;
    n = x[OPW-1] ? (~x + OPW'(1)) : x;
    if (x == MINV) n = {1'b0, {MAGW{1'b1}}};
    return PADW'(n[MAGW-1:0]);
  endfunction

  // stage 1: sign, clamp detect, magnitudes
  logic            v1, s1, c1;
  logic [PADW-1:0] ma1, mb1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; s1 <= 1'b0; c1 <= 1'b0; ma1 <= '0; mb1 <= '0;
    end else begin
      v1  <= valid_in;
      s1  <= a_in[OPW-1] ^ b_in[OPW-1];
      c1  <= (a_in == MINV) || (b_in == MINV);
      ma1 <= mag_of(a_in);
      mb1 <= mag_of(b_in);
    end
  end

  // stage 2: nine limb products, one per tile
  logic           v2, s2, c2;
  logic [PPW-1:0] pp [NT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; s2 <= 1'b0; c2 <= 1'b0;
      for (int k = 0; k < NT; k++) pp[k] <= '0;
    end else begin
      v2 <= v1; s2 <= s1; c2 <= c1;
      for (int k = 0; k < NT; k++)
        pp[k] <= PPW'(ma1[(k/3)*LW +: LW]) * PPW'(mb1[(k%3)*LW +: LW]);
    end
  end

  // stage 3: weighted sum and sign
  logic [RW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NT; k++)
      acc = acc + (RW'(pp[k]) << (LW * ((k/3) + (k%3))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0; clamp_out <= 1'b0; prod_out <= '0;
    end else begin
      valid_out <= v2;
      clamp_out <= c2;
      prod_out  <= s2 ? ('0 - acc) : acc;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |-> ##3 valid_out);
  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |-> ##3 !valid_out);
  assert_zero_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (a_in == '0)) |-> ##3 (prod_out == '0));
  assert_neg_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (a_in == '1) && (b_in == OPW'(1))) |-> ##3 (prod_out == '1));
  assert_clamp_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ((a_in == MINV) || (b_in == MINV))) |-> ##3 clamp_out);
  assert_no_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (a_in != MINV) && (b_in != MINV)) |-> ##3 !clamp_out);
  assert_reset_clear_R6: assert property (@(posedge clk)
    !rst_n |-> (!valid_out && !clamp_out && (prod_out == '0)));
endmodule

// File: tb/wide_tile_mult_tb.sv
`timescale 1ns/1ps
module wide_tile_mult_tb_top;
  localparam int NS = 16384;
  localparam int NB = 600;
  localparam logic [51:0] MIN52 = {1'b1, 51'd0};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, vin, svin;
  logic [51:0] a, b;
  logic [6:0]  sa, sb;
  logic        vout, cout, svout, scout;
  logic [103:0] prod;
  logic [13:0]  sprod;

  int checks = 0, errors = 0;
  bit done = 0;

  wide_tile_mult #(.OPW(52)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(vin), .a_in(a), .b_in(b),
    .valid_out(vout), .prod_out(prod), .clamp_out(cout));
  wide_tile_mult #(.OPW(7)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .valid_in(svin), .a_in(sa), .b_in(sb),
    .valid_out(svout), .prod_out(sprod), .clamp_out(scout));

  task automatic chk(input string req, input logic ok,
                     input logic [103:0] act, input logic [103:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic signed [103:0] sx7(input logic [6:0] x);
    if (x == 7'h40) return -104'sd63;
    return {{97{x[6]}}, x};
  endfunction

  function automatic logic signed [103:0] sx52(input logic [51:0] x);
    if (x == MIN52) return {{52{1'b1}}, MIN52 + 52'd1};
    return {{52{x[51]}}, x};
  endfunction

  function automatic string tag(input logic clamped, input logic signed [103:0] e);
    if (clamped) return "R4";
    if (e < 0 || e == 0) return "R3";
    return "R1";
  endfunction

  logic [51:0] ba [NB];
  logic [51:0] bb [NB];
  logic        bv [NB];
  logic [51:0] corner [8];

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; vin = 1'b0; svin = 1'b0; a = '0; b = '0; sa = '0; sb = '0;
    corner[0] = 52'd0;            corner[1] = 52'd1;
    corner[2] = '1;               corner[3] = {1'b0, {51{1'b1}}};
    corner[4] = MIN52;            corner[5] = {1'b1, 50'd0, 1'b1};
    corner[6] = 52'h20000;        corner[7] = 52'h3FFFFFFFF;
    for (int t = 0; t < NB; t++) begin
      if (t < 64) begin
        ba[t] = corner[t/8]; bb[t] = corner[t%8]; bv[t] = 1'b1;
      end else begin
        ba[t] = {$urandom, $urandom} & {52{1'b1}};
        bb[t] = {$urandom, $urandom} & {52{1'b1}};
        bv[t] = (t % 7) != 6;
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 valid", !vout && !svout, {102'd0, vout, svout}, 104'd0);
    chk("R6 prod", prod == '0 && sprod == '0, prod, 104'd0);
    chk("R6 clamp", !cout && !scout, {102'd0, cout, scout}, 104'd0);
    rst_n = 1'b1;

    // exhaustive small sweep, back to back (R7)
    for (int t = 0; t < NS + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        int k;
        logic [6:0] xa, xb;
        logic signed [103:0] e;
        logic cl;
        k = t - 3;
        xa = 7'(k >> 7); xb = 7'(k);
        e = sx7(xa) * sx7(xb);
        cl = (xa == 7'h40) || (xb == 7'h40);
        chk("R7 valid", svout, {103'd0, svout}, 104'd1);
        chk(tag(cl, e), sprod == e[13:0], {90'd0, sprod}, {90'd0, e[13:0]});
        chk(cl ? "R4 flag" : "R5 flag", scout == cl, {103'd0, scout}, {103'd0, cl});
      end
      if (t < NS) begin
        svin = 1'b1; sa = 7'(t >> 7); sb = 7'(t);
      end else svin = 1'b0;
    end

    // wide instance: corners then random with gaps
    for (int t = 0; t < NB + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        int k;
        logic signed [103:0] e;
        logic cl;
        k = t - 3;
        chk("R2 valid", vout == bv[k], {103'd0, vout}, {103'd0, bv[k]});
        if (bv[k]) begin
          e = sx52(ba[k]) * sx52(bb[k]);
          cl = (ba[k] == MIN52) || (bb[k] == MIN52);
          chk(tag(cl, e), prod == e, prod, e);
          chk(cl ? "R4 flag" : "R5 flag", cout == cl, {103'd0, cout}, {103'd0, cl});
        end
      end
      if (t < NB) begin
        vin = bv[t]; a = ba[t]; b = bb[t];
      end else vin = 1'b0;
    end

    summary();
  end
endmodule